// File: doc/BRIEF.md
# In-band command cell receiver (4-bit nibble stream)

This block watches an ATM cell stream carried four bits per clock with a one-clock frame marker. Each cell is 106 nibbles: a ten-nibble header and then 48 payload bytes, each sent high nibble first. The block counts nibbles from the marker and checks the header routing fields against its switch address. A cell whose VPI is zero, whose VCI upper byte is zero and whose VCI lower byte equals the switch address is a command cell. All other cells go out on the output stream unchanged, with a fixed delay.

A command cell never reaches the output. When the block is idle, it keeps the first four payload bytes as command fields (command, sub-command, cell number, data count). It writes the next thirteen bytes into a small data buffer that the executor reads through a synchronous read port. After the last nibble it pulses `cmd_ready` and holds `cmd_busy` until the executor pulses `cmd_done`. A command cell that arrives while a command is held is discarded and sets a sticky overflow flag. The switch address comes from a strap input at reset. The executor can replace it after it runs a change-address command.

Top module: `cmdrx_cell_receiver`

## Requirements
- R1: After reset, `out_sof`, `out_nib`, `cmd_ready`, `cmd_busy` and `cmd_overflow` are all zero.
- R2: A non-command cell is forwarded with all 106 nibbles in order. `out_sof` is high exactly 9 clocks after the cycle in which `in_sof` was high, and nibble 0 follows one clock after `out_sof`.
- R3: Back-to-back cells are forwarded intact. Here the next `in_sof` coincides with nibble 105 of the previous cell.
- R4: The header nibble order is GFC, VPI[7:4], VPI[3:0], VCI[15:12], VCI[11:8], VCI[7:4], VCI[3:0], PTI/CLP, HEC[7:4], HEC[3:0]. A cell is a command cell only when VPI = 0x00, VCI[15:8] = 0x00 and VCI[7:0] equals the switch address. GFC, PTI/CLP and HEC have no influence on the match.
- R5: A command cell is never forwarded. No marker is emitted for it, and `out_nib` is zero during its slot.
- R6: For an accepted command, payload byte 0 appears on `cmd_code`, byte 1 on `cmd_sub`, byte 2 on `cmd_num` and byte 3 on `cmd_count`. `cmd_ready` is high for exactly one clock, in the cycle after the cycle that carries nibble 105.
- R7: Payload bytes 4 to 16 are stored as data bytes 0 to 12. `rd_data` shows the byte at `rd_addr` one clock after the address is applied.
- R8: `cmd_busy` rises together with `cmd_ready` and stays high until a `cmd_done` pulse. A command cell that arrives while busy is dropped: the fields, data and `cmd_busy` are unchanged, and `cmd_overflow` is set and stays set.
- R9: A data count above DATA_MAX (13) is presented as 13. Values up to 13 are presented as they are.
- R10: At reset the switch address loads from `strap_addr`. A one-clock `addr_load` replaces it with `addr_new`, after which only the new address matches.
- R11: After `cmd_done` clears `cmd_busy`, the next command cell is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and both streams |
| rst | input | 1 | Synchronous reset, active high |
| strap_addr | input | 8 | Switch address loaded at reset |
| addr_load | input | 1 | Load `addr_new` as the switch address |
| addr_new | input | 8 | Replacement switch address |
| in_sof | input | 1 | Input frame marker, one clock before nibble 0 |
| in_nib | input | 4 | Input nibble |
| out_sof | output | 1 | Output frame marker |
| out_nib | output | 4 | Output nibble |
| cmd_ready | output | 1 | One-clock strobe: command captured |
| cmd_busy | output | 1 | A command is held |
| cmd_done | input | 1 | Executor has finished the held command |
| cmd_code | output | 8 | Payload byte 0 |
| cmd_sub | output | 8 | Payload byte 1 |
| cmd_num | output | 8 | Payload byte 2 |
| cmd_count | output | 8 | Payload byte 3, clamped to DATA_MAX |
| rd_addr | input | 4 | Data buffer read address |
| rd_data | output | 8 | Data buffer read data, one clock after address |
| cmd_overflow | output | 1 | Sticky: a command cell was dropped while busy |

## Verification
The bench builds the block with its default DATA_MAX of 13. With that value the clamp boundary (a count of exactly 13 against one of 0x20) can be reached. Every buffer entry can also be read back, and payload bytes beyond the buffer are shown to be discarded. The fixed cell length and the nine-clock delay let a scoreboard predict the exact cycle of each forwarded marker. This covers back-to-back cells and cells that differ from a command cell in a single routing field.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int NIB_W      = 4;
  localparam int CELL_NIBS  = 106;
  localparam int HDR_NIBS   = 10;
  localparam int MATCH_NIB  = 6;   // last routing nibble, VCI[3:0]
  localparam int FIELD_BYTES = 4;
  localparam int IDX_W      = $clog2(CELL_NIBS);
  // header decided after MATCH_NIB, one clock to register, one to gate
  localparam int FWD_LAT    = MATCH_NIB + 3;

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_NIBS - 1);
  localparam logic [IDX_W-1:0] MATCH_IDX = IDX_W'(MATCH_NIB);
  localparam logic [IDX_W-1:0] HDR_IDX   = IDX_W'(HDR_NIBS);
endpackage

// File: rtl/cmdrx_cell_track.sv
module cmdrx_cell_track
  import cmdrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_sof,
  input  logic [NIB_W-1:0] in_nib,
  input  logic [7:0]       sw_addr,
  output logic             in_cell,
  output logic [IDX_W-1:0] idx,
  output logic             hit_now,
  output logic             cell_match
);
  logic hdr_ok;

  always_comb
    hit_now = in_cell && (idx == MATCH_IDX) && hdr_ok && (in_nib == sw_addr[3:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cell    <= 1'b0;
      idx        <= '0;
      hdr_ok     <= 1'b0;
      cell_match <= 1'b0;
    end else begin
      if (in_sof) begin
        in_cell    <= 1'b1;
        idx        <= '0;
        cell_match <= 1'b0;
      end else begin
        if (in_cell) begin
          if (idx == LAST_IDX) in_cell <= 1'b0;
          else                 idx     <= idx + IDX_W'(1);
        end
        if (hit_now) cell_match <= 1'b1;
      end
      if (in_cell) begin
        if (idx == '0)
          hdr_ok <= 1'b1;
        else if (idx < IDX_W'(5))
          hdr_ok <= hdr_ok && (in_nib == '0);
        else if (idx == IDX_W'(5))
          hdr_ok <= hdr_ok && (in_nib == sw_addr[7:4]);
      end
    end
  end
endmodule

// File: rtl/cmdrx_fwd_delay.sv
module cmdrx_fwd_delay #(
  parameter int LAT = 9,
  parameter int NW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_sof,
  input  logic [NW-1:0] in_nib,
  input  logic          drop,
  output logic          out_sof,
  output logic [NW-1:0] out_nib
);
  localparam int STG = LAT - 1;

  logic [STG-1:0] sof_sr;
  logic [NW-1:0]  nib_sr [STG];
  logic           pass_en;
  logic           head_sof;

  assign head_sof = sof_sr[STG-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sof_sr  <= '0;
      for (int k = 0; k < STG; k++) nib_sr[k] <= '0;
      pass_en <= 1'b0;
      out_sof <= 1'b0;
      out_nib <= '0;
    end else begin
      sof_sr    <= {sof_sr[STG-2:0], in_sof};
      nib_sr[0] <= in_nib;
      for (int k = 1; k < STG; k++) nib_sr[k] <= nib_sr[k-1];
      if (head_sof) pass_en <= !drop;
      out_sof <= head_sof && !drop;
      out_nib <= pass_en ? nib_sr[STG-1] : '0;
    end
  end
endmodule

// File: rtl/cmdrx_payload_buf.sv
module cmdrx_payload_buf #(
  parameter int DEPTH = 13,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cmdrx_cell_receiver.sv
module cmdrx_cell_receiver
  import cmdrx_pkg::*;
#(
  parameter int DATA_MAX = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [7:0]                  strap_addr,
  input  logic                        addr_load,
  input  logic [7:0]                  addr_new,
  input  logic                        in_sof,
  input  logic [3:0]                  in_nib,
  output logic                        out_sof,
  output logic [3:0]                  out_nib,
  output logic                        cmd_ready,
  output logic                        cmd_busy,
  input  logic                        cmd_done,
  output logic [7:0]                  cmd_code,
  output logic [7:0]                  cmd_sub,
  output logic [7:0]                  cmd_num,
  output logic [7:0]                  cmd_count,
  input  logic [$clog2(DATA_MAX)-1:0] rd_addr,
  output logic [7:0]                  rd_data,
  output logic                        cmd_overflow
);
  localparam int AW = $clog2(DATA_MAX);
  localparam int KW = IDX_W - 1;
  localparam logic [7:0]    CNT_MAX  = 8'(DATA_MAX);
  localparam logic [KW-1:0] DAT_LO   = KW'(FIELD_BYTES);
  localparam logic [KW-1:0] DAT_HI   = KW'(FIELD_BYTES + DATA_MAX);

  logic [7:0]       sw_addr;
  logic             in_cell, hit_now, cell_match, capturing;
  logic [IDX_W-1:0] idx, pl_off;
  logic [KW-1:0]    byte_k, data_idx;
  logic [3:0]       hi_nib;
  logic             in_payload, byte_done, end_evt, buf_we;
  logic [7:0]       byte_val;

  cmdrx_cell_track u_track (
    .clk(clk), .rst(rst), .in_sof(in_sof), .in_nib(in_nib), .sw_addr(sw_addr),
    .in_cell(in_cell), .idx(idx), .hit_now(hit_now), .cell_match(cell_match)
  );

  cmdrx_fwd_delay #(.LAT(FWD_LAT), .NW(NIB_W)) u_fwd (
    .clk(clk), .rst(rst), .in_sof(in_sof), .in_nib(in_nib), .drop(cell_match),
    .out_sof(out_sof), .out_nib(out_nib)
  );

  always_comb begin
    in_payload = in_cell && (idx >= HDR_IDX);
    pl_off     = idx - HDR_IDX;
    byte_k     = pl_off[IDX_W-1:1];
    byte_val   = {hi_nib, in_nib};
    byte_done  = capturing && in_payload && pl_off[0];
    data_idx   = byte_k - DAT_LO;
    buf_we     = byte_done && (byte_k >= DAT_LO) && (byte_k < DAT_HI);
    end_evt    = in_cell && (idx == LAST_IDX);
  end

  cmdrx_payload_buf #(.DEPTH(DATA_MAX), .W(8)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_addr(data_idx[AW-1:0]), .wr_data(byte_val),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_addr      <= strap_addr;
      capturing    <= 1'b0;
      hi_nib       <= '0;
      cmd_ready    <= 1'b0;
      cmd_busy     <= 1'b0;
      cmd_overflow <= 1'b0;
      cmd_code     <= '0;
      cmd_sub      <= '0;
      cmd_num      <= '0;
      cmd_count    <= '0;
    end else begin
      if (addr_load) sw_addr <= addr_new;
      if (in_payload && !pl_off[0]) hi_nib <= in_nib;
      if (byte_done) begin
        unique case (byte_k)
          KW'(0):  cmd_code <= byte_val;
          KW'(1):  cmd_sub  <= byte_val;
          KW'(2):  cmd_num  <= byte_val;
          KW'(3):  cmd_count <= (byte_val > CNT_MAX) ? CNT_MAX : byte_val;
          default: ;
        endcase
      end
      cmd_ready <= 1'b0;
      if (cmd_done) cmd_busy <= 1'b0;
      if (end_evt && capturing) begin
        cmd_ready <= 1'b1;
        cmd_busy  <= 1'b1;
      end
      if (in_sof || end_evt) capturing <= 1'b0;
      else if (hit_now && !cmd_busy) capturing <= 1'b1;
      if (hit_now && cmd_busy) cmd_overflow <= 1'b1;
    end
  end

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |=> !cmd_ready);
  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> cmd_busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_busy && !cmd_done |=> cmd_busy);
  // R8
  fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_busy && !cmd_done |=> $stable(cmd_code) && $stable(cmd_count) && $stable(cmd_num));
  // R8
  no_overflow_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_overflow |=> cmd_overflow);
  // R9
  always_ff @(posedge clk) begin
    if (!rst) count_clamp_chk: assert (cmd_count <= CNT_MAX);
  end
endmodule

// File: tb/cmdrx_cell_receiver_test.sv
module cmdrx_cell_receiver_test;
  localparam int DMAX = 13;
  localparam int LAT  = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] strap_addr = 8'h5A;
  logic       addr_load = 1'b0;
  logic [7:0] addr_new = 8'h00;
  logic       in_sof = 1'b0;
  logic [3:0] in_nib = 4'h0;
  logic       out_sof;
  logic [3:0] out_nib;
  logic       cmd_ready, cmd_busy, cmd_overflow;
  logic       cmd_done = 1'b0;
  logic [7:0] cmd_code, cmd_sub, cmd_num, cmd_count, rd_data;
  logic [3:0] rd_addr = 4'h0;

  always #2 clk = ~clk;

  cmdrx_cell_receiver #(.DATA_MAX(DMAX)) uut (
    .clk(clk), .rst(rst), .strap_addr(strap_addr), .addr_load(addr_load),
    .addr_new(addr_new), .in_sof(in_sof), .in_nib(in_nib), .out_sof(out_sof),
    .out_nib(out_nib), .cmd_ready(cmd_ready), .cmd_busy(cmd_busy),
    .cmd_done(cmd_done), .cmd_code(cmd_code), .cmd_sub(cmd_sub),
    .cmd_num(cmd_num), .cmd_count(cmd_count), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmd_overflow(cmd_overflow)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0] exp_nib [$];
  int         exp_t [$];
  int         remain = 0;
  logic [3:0] tail = 4'h0;
  logic [7:0] pl [48];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [3:0] e;
    int t0;
    if (!rst) begin
      if (remain > 0) begin
        e = exp_nib.pop_front();
        check(out_nib == e, "R2", "forwarded nibble", out_nib, e);
        remain--;
      end else begin
        check(out_nib == 4'h0, "R5", "nibble outside forwarded cell", out_nib, 0);
      end
      if (out_sof) begin
        if (exp_t.size() == 0) check(1'b0, "R5", "unexpected frame marker", 1, 0);
        else begin
          t0 = exp_t.pop_front();
          check(cyc - t0 == LAT, "R2", "marker latency", cyc - t0, LAT);
          remain = 106;
        end
      end
    end
  end

  task automatic fill_pl(input logic [7:0] code, input logic [7:0] sub,
                         input logic [7:0] num, input logic [7:0] cnt,
                         input logic [7:0] base);
    pl[0] = code; pl[1] = sub; pl[2] = num; pl[3] = cnt;
    for (int k = 4; k < 48; k++) pl[k] = base + 8'(k - 4);
  endtask

  task automatic send_cell(input logic [7:0] vpi, input logic [15:0] vci,
                           input logic [3:0] gfc, input logic [3:0] ptc,
                           input logic [7:0] hec, input bit fwd);
    logic [3:0] n [106];
    n[0] = gfc; n[1] = vpi[7:4]; n[2] = vpi[3:0];
    n[3] = vci[15:12]; n[4] = vci[11:8]; n[5] = vci[7:4]; n[6] = vci[3:0];
    n[7] = ptc; n[8] = hec[7:4]; n[9] = hec[3:0];
    for (int k = 0; k < 48; k++) begin
      n[10+2*k] = pl[k][7:4];
      n[11+2*k] = pl[k][3:0];
    end
    @(negedge clk);
    in_sof = 1'b1;
    in_nib = tail;
    if (fwd) begin
      exp_t.push_back(cyc);
      for (int k = 0; k < 106; k++) exp_nib.push_back(n[k]);
    end
    for (int k = 0; k < 105; k++) begin
      @(negedge clk);
      in_sof = 1'b0;
      in_nib = n[k];
    end
    tail = n[105];
  endtask

  task automatic flush(input int cycles);
    @(negedge clk);
    in_sof = 1'b0;
    in_nib = tail;
    tail = 4'h0;
    repeat (cycles - 1) begin
      @(negedge clk);
      in_nib = 4'h0;
    end
  endtask

  task automatic finish_cmd(input bit exp_ready);
    @(negedge clk);
    in_nib = tail;
    tail = 4'h0;
    check(cmd_ready == 1'b0, "R6", "ready before last nibble", cmd_ready, 0);
    @(negedge clk);
    in_nib = 4'h0;
    check(cmd_ready == exp_ready, "R6", "ready after last nibble", cmd_ready, exp_ready);
    @(negedge clk);
    check(cmd_ready == 1'b0, "R6", "ready single pulse", cmd_ready, 0);
  endtask

  task automatic done_pulse();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    check(cmd_busy == 1'b0, "R11", "busy cleared by done", cmd_busy, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(out_sof == 0 && out_nib == 0, "R1", "output stream idle", out_nib, 0);
    check(cmd_ready == 0 && cmd_busy == 0, "R1", "command idle", cmd_busy, 0);
    check(cmd_overflow == 0, "R1", "overflow clear", cmd_overflow, 0);

    // R2 R3 R4: three non-command cells back to back
    fill_pl(8'h11, 8'h22, 8'h33, 8'h04, 8'h10);
    send_cell(8'h01, 16'h005A, 4'h0, 4'h0, 8'h00, 1'b1);
    send_cell(8'h00, 16'h015A, 4'h3, 4'h1, 8'h55, 1'b1);
    send_cell(8'h00, 16'h005B, 4'h0, 4'h0, 8'h00, 1'b1);
    flush(15);
    check(exp_t.size() == 0, "R3", "all back-to-back cells emitted", exp_t.size(), 0);

    // R4 R5 R6 R7: command cell with GFC/PTI/HEC set
    fill_pl(8'h81, 8'h02, 8'h33, 8'h05, 8'hC0);
    send_cell(8'h00, 16'h005A, 4'hF, 4'hF, 8'hE7, 1'b0);
    finish_cmd(1'b1);
    check(cmd_code == 8'h81, "R6", "command byte", cmd_code, 8'h81);
    check(cmd_sub  == 8'h02, "R6", "sub-command byte", cmd_sub, 8'h02);
    check(cmd_num  == 8'h33, "R6", "cell number byte", cmd_num, 8'h33);
    check(cmd_count == 8'h05, "R9", "count below limit kept", cmd_count, 8'h05);
    check(cmd_busy == 1'b1, "R8", "busy after ready", cmd_busy, 1);
    for (int i = 0; i < DMAX; i++) begin
      @(negedge clk); rd_addr = 4'(i);
      @(negedge clk);
      check(rd_data == 8'hC0 + 8'(i), "R7", "data byte", rd_data, 8'hC0 + 8'(i));
    end
    check(cmd_overflow == 1'b0, "R8", "no overflow yet", cmd_overflow, 0);

    // R8: command while busy is dropped, traffic still forwarded
    fill_pl(8'h44, 8'h09, 8'h34, 8'h02, 8'h20);
    send_cell(8'h00, 16'h005A, 4'h0, 4'h0, 8'h00, 1'b0);
    finish_cmd(1'b0);
    check(cmd_overflow == 1'b1, "R8", "overflow set", cmd_overflow, 1);
    check(cmd_code == 8'h81, "R8", "fields kept while busy", cmd_code, 8'h81);
    check(cmd_busy == 1'b1, "R8", "still busy", cmd_busy, 1);
    @(negedge clk); rd_addr = 4'd0;
    @(negedge clk);
    check(rd_data == 8'hC0, "R8", "data kept while busy", rd_data, 8'hC0);
    send_cell(8'h02, 16'h0000, 4'h0, 4'h0, 8'h00, 1'b1);
    flush(15);

    // R11 R9: accept after done, count clamped
    done_pulse();
    fill_pl(8'h82, 8'h03, 8'h35, 8'h20, 8'h50);
    send_cell(8'h00, 16'h005A, 4'h0, 4'h0, 8'h00, 1'b0);
    finish_cmd(1'b1);
    check(cmd_code == 8'h82, "R11", "new command accepted", cmd_code, 8'h82);
    check(cmd_count == 8'd13, "R9", "count 0x20 clamped", cmd_count, 13);
    check(cmd_overflow == 1'b1, "R8", "overflow sticky", cmd_overflow, 1);
    @(negedge clk); rd_addr = 4'd12;
    @(negedge clk);
    check(rd_data == 8'h5C, "R7", "last data byte", rd_data, 8'h5C);
    done_pulse();

    // R10: address change
    @(negedge clk); addr_load = 1'b1; addr_new = 8'h33;
    @(negedge clk); addr_load = 1'b0;
    fill_pl(8'h99, 8'h01, 8'h36, 8'h01, 8'h70);
    send_cell(8'h00, 16'h005A, 4'h0, 4'h0, 8'h00, 1'b1);
    flush(15);
    check(cmd_busy == 1'b0, "R10", "old address not accepted", cmd_busy, 0);
    fill_pl(8'h83, 8'h04, 8'h37, 8'h0D, 8'h90);
    send_cell(8'h00, 16'h0033, 4'h0, 4'h0, 8'h00, 1'b0);
    finish_cmd(1'b1);
    check(cmd_code == 8'h83, "R10", "new address accepted", cmd_code, 8'h83);
    check(cmd_count == 8'd13, "R9", "count 13 at limit", cmd_count, 13);
    done_pulse();

    flush(20);
    check(exp_t.size() == 0 && remain == 0, "R2", "scoreboard drained", exp_t.size(), 0);
    report();
  end
endmodule